// File: doc/BRIEF.md
# 64-bit Global Comparator Timer

This block is a free-running 64-bit up-counter with a single 64-bit comparator. Software reaches both through a word-addressed register bus. The counter and the comparator each appear as a low word and a high word. Software can preload the counter while it is stopped, start it, and read it live at any time. To take a consistent 64-bit sample, software reads high, then low, then high again, and retries if the two high reads differ.

When the count equals the comparator value while the comparator is enabled, a pending bit is set. The `irq` output is that pending bit gated by an enable register. In one-shot mode the comparator fires once and then waits to be rewritten. In auto-increment mode it adds an increment register to itself at every match, which gives a periodic interrupt with no software in the loop.

Each write to a comparator word, the increment register, the control register or a counter word raises a sticky write-done flag one cycle after the write takes effect. Software clears these flags by writing 1 to them.

The comparator is sequenced by a three-state machine:
- `CMP_OFF`: comparator disabled.
- `CMP_ARMED`: matches are tested.
- `CMP_SPENT`: a one-shot has fired.

Its transitions are:
- off→armed: a control write that sets the enable bit.
- armed→off and spent→off: a control write that clears the enable bit.
- armed→spent: a match while auto-increment is off.
- spent→armed: a write to either comparator word.

Top module: `gct_timer`

Register word addresses (`bus_addr`):

| Address | Register |
|---|---|
| 0 | count low word |
| 1 | count high word |
| 2 | compare low word |
| 3 | compare high word |
| 4 | increment |
| 5 | control: bit0 run, bit1 compare enable, bit2 auto-increment |
| 6 | interrupt enable (bit0) |
| 7 | interrupt status (bit0, write 1 to clear) |
| 8 | write-done flags: bit0 compare low, bit1 compare high, bit2 increment, bit16 control |
| 9 | count write-done flags: bit0 low, bit1 high |

## Requirements
- R1: After reset every readable register reads 0 and `irq` is low.
- R2: While control bit0 is 1, the count rises by exactly one per clock, carrying from the low word into the high word. While control bit0 is 0, the count holds.
- R3: A write to address 0 or 1 replaces that 32-bit word of the count, and the count does not also increment in that cycle.
- R4: With compare enabled, the status bit (address 7, bit0) is set at the clock edge at which the current count equals the 64-bit compare value. After a control write with run=1 and enable=1 from a count C toward a compare value C+k, the status bit is seen set after k+1 edges.
- R5: With control bit2 set, each match adds the increment (address 4) to the compare value, so successive matches are exactly `increment` cycles apart.
- R6: `irq` equals the status bit ANDed with address 6 bit0. A match with the enable at 0 sets the status bit but leaves `irq` low.
- R7: Writing 1 to address 7 bit0 clears the status bit. Writing 0 there has no effect.
- R8: Clearing the compare-enable bit stops further matches but does not clear a status bit that is already set.
- R9: Each flag at address 8 (bit0 compare low, bit1 compare high, bit2 increment, bit16 control) and at address 9 (bit0 count low, bit1 count high) reads 0 right after its write edge and 1 one cycle later.
- R10: Writing 1 to a write-done flag clears it. Writing 0 leaves it set. A flag that is being set in the same cycle as a clear stays set.
- R11: Count reads are live: two reads one cycle apart while running differ by one, with no snapshot latch.
- R12: After a one-shot match the comparator stays spent: it does not fire again, even when the count passes the compare value again, until a compare word is rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bus_wr | input | 1 | write strobe, one word per cycle |
| bus_addr | input | 4 | register word address |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data for `bus_addr`, combinational |
| irq | output | 1 | level interrupt |

## Verification
The bench builds the block with its default 32-bit word width, so the count and compare values are true 64-bit quantities. By preloading the count just below a word boundary, the low-to-high carry comes within a few cycles of the start.

The bench sweeps the one-shot distance from zero to five cycles and the auto-increment period from three to six cycles. For each case it computes the expected match edge arithmetically. It also walks every write-done flag through its set and clear steps, including a clear that collides with a set.

// File: rtl/gct_pkg.sv
package gct_pkg;
    localparam int unsigned ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CNT_LO   = 4'd0;
    localparam logic [ADDR_W-1:0] A_CNT_HI   = 4'd1;
    localparam logic [ADDR_W-1:0] A_CMP_LO   = 4'd2;
    localparam logic [ADDR_W-1:0] A_CMP_HI   = 4'd3;
    localparam logic [ADDR_W-1:0] A_INCR     = 4'd4;
    localparam logic [ADDR_W-1:0] A_CTRL     = 4'd5;
    localparam logic [ADDR_W-1:0] A_IRQ_EN   = 4'd6;
    localparam logic [ADDR_W-1:0] A_IRQ_STAT = 4'd7;
    localparam logic [ADDR_W-1:0] A_WSTAT    = 4'd8;
    localparam logic [ADDR_W-1:0] A_CNT_WST  = 4'd9;

    localparam int unsigned RUN_BIT  = 0;
    localparam int unsigned EN_BIT   = 1;
    localparam int unsigned AUTO_BIT = 2;
    localparam int unsigned CTRL_WS_BIT = 16;

    typedef enum logic [1:0] {
        CMP_OFF   = 2'd0,
        CMP_ARMED = 2'd1,
        CMP_SPENT = 2'd2
    } cmp_state_e;
endpackage

// File: rtl/gct_counter.sv
module gct_counter #(
    parameter int unsigned DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic [DATA_W-1:0]     wdata,
    output logic [2*DATA_W-1:0]   cnt
);
    localparam int unsigned CNT_W = 2 * DATA_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (wr_lo) begin
            cnt[DATA_W-1:0] <= wdata;
        end else if (wr_hi) begin
            cnt[CNT_W-1:DATA_W] <= wdata;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2: one step per cycle while running
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wr_lo && !wr_hi) |=> cnt == $past(cnt) + 1'b1);

    // R2: held while stopped
    p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_lo && !wr_hi) |=> $stable(cnt));
endmodule

// File: rtl/gct_compare.sv
module gct_compare
    import gct_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*DATA_W-1:0]   cnt,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  wr_cmp_lo,
    input  logic                  wr_cmp_hi,
    input  logic                  wr_incr,
    input  logic                  wr_ctrl,
    input  logic                  auto_mode,
    input  logic                  pend_clr,
    output logic [2*DATA_W-1:0]   cmp_q,
    output logic [DATA_W-1:0]     incr_q,
    output logic                  pending,
    output cmp_state_e            state_q
);
    localparam int unsigned CNT_W = 2 * DATA_W;

    cmp_state_e state_d;
    logic       match;
    logic       en_new;

    assign en_new = wdata[EN_BIT];
    assign match  = (state_q == CMP_ARMED) && (cnt == cmp_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMP_OFF: begin
                if (wr_ctrl && en_new) state_d = CMP_ARMED;
            end
            CMP_ARMED: begin
                if (wr_ctrl && !en_new)        state_d = CMP_OFF;
                else if (match && !auto_mode)  state_d = CMP_SPENT;
            end
            CMP_SPENT: begin
                if (wr_ctrl && !en_new)             state_d = CMP_OFF;
                else if (wr_cmp_lo || wr_cmp_hi)   state_d = CMP_ARMED;
            end
            default: state_d = CMP_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CMP_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q   <= '0;
            incr_q  <= '0;
            pending <= 1'b0;
        end else begin
            if (wr_cmp_lo)
                cmp_q[DATA_W-1:0] <= wdata;
            else if (wr_cmp_hi)
                cmp_q[CNT_W-1:DATA_W] <= wdata;
            else if (match && auto_mode)
                cmp_q <= cmp_q + {{DATA_W{1'b0}}, incr_q};
            if (wr_incr)
                incr_q <= wdata;
            if (match)
                pending <= 1'b1;
            else if (pend_clr)
                pending <= 1'b0;
        end
    end

    // R4: a new pending status only comes from an armed comparator
    p_pend_from_armed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(state_q) == CMP_ARMED);

    // R5: periodic reload adds the increment
    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (match && auto_mode && !wr_cmp_lo && !wr_cmp_hi)
        |=> cmp_q == $past(cmp_q) + {{DATA_W{1'b0}}, $past(incr_q)});

    // R8: disabled comparator keeps an existing pending status
    p_off_keeps_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CMP_OFF && pending && !pend_clr) |=> pending);

    // R12: a spent one-shot raises nothing new
    p_spent_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CMP_SPENT && !pending) |=> !pending);
endmodule

// File: rtl/gct_wstat.sv
module gct_wstat #(
    parameter int unsigned NFLAG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NFLAG-1:0]  set,
    input  logic [NFLAG-1:0]  clr,
    output logic [NFLAG-1:0]  flags
);
    logic [NFLAG-1:0] set_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            set_q <= '0;
            flags <= '0;
        end else begin
            set_q <= set;
            flags <= (flags & ~clr) | set_q;
        end
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        // R9: a flag rises two edges after its write strobe is seen
        p_flag_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags[i]) |-> $past(set[i], 2));
        // R10: a flag only falls on a clear request
        p_flag_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flags[i]) |-> $past(clr[i]));
    end
endmodule

// File: rtl/gct_timer.sv
module gct_timer
    import gct_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  irq
);
    localparam int unsigned CNT_W = 2 * DATA_W;

    logic wr_cnt_lo, wr_cnt_hi, wr_cmp_lo, wr_cmp_hi, wr_incr, wr_ctrl;
    logic wr_ien, wr_istat, wr_wst, wr_cwst;

    assign wr_cnt_lo = bus_wr && (bus_addr == A_CNT_LO);
    assign wr_cnt_hi = bus_wr && (bus_addr == A_CNT_HI);
    assign wr_cmp_lo = bus_wr && (bus_addr == A_CMP_LO);
    assign wr_cmp_hi = bus_wr && (bus_addr == A_CMP_HI);
    assign wr_incr   = bus_wr && (bus_addr == A_INCR);
    assign wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
    assign wr_ien    = bus_wr && (bus_addr == A_IRQ_EN);
    assign wr_istat  = bus_wr && (bus_addr == A_IRQ_STAT);
    assign wr_wst    = bus_wr && (bus_addr == A_WSTAT);
    assign wr_cwst   = bus_wr && (bus_addr == A_CNT_WST);

    logic [2:0] ctrl_q;
    logic       ien_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ien_q  <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata[2:0];
            if (wr_ien)  ien_q  <= bus_wdata[0];
        end
    end

    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cmp;
    logic [DATA_W-1:0] incr;
    logic              pending;
    cmp_state_e        cstate;

    gct_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctrl_q[RUN_BIT]),
        .wr_lo (wr_cnt_lo),
        .wr_hi (wr_cnt_hi),
        .wdata (bus_wdata),
        .cnt   (cnt)
    );

    gct_compare #(.DATA_W(DATA_W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt       (cnt),
        .wdata     (bus_wdata),
        .wr_cmp_lo (wr_cmp_lo),
        .wr_cmp_hi (wr_cmp_hi),
        .wr_incr   (wr_incr),
        .wr_ctrl   (wr_ctrl),
        .auto_mode (ctrl_q[AUTO_BIT]),
        .pend_clr  (wr_istat && bus_wdata[0]),
        .cmp_q     (cmp),
        .incr_q    (incr),
        .pending   (pending),
        .state_q   (cstate)
    );

    logic [3:0] gflags;
    logic [1:0] cflags;

    gct_wstat #(.NFLAG(4)) u_gwst (
        .clk   (clk),
        .rst_n (rst_n),
        .set   ({wr_ctrl, wr_incr, wr_cmp_hi, wr_cmp_lo}),
        .clr   ({4{wr_wst}} & {bus_wdata[CTRL_WS_BIT], bus_wdata[2:0]}),
        .flags (gflags)
    );

    gct_wstat #(.NFLAG(2)) u_cwst (
        .clk   (clk),
        .rst_n (rst_n),
        .set   ({wr_cnt_hi, wr_cnt_lo}),
        .clr   ({2{wr_cwst}} & bus_wdata[1:0]),
        .flags (cflags)
    );

    assign irq = pending & ien_q;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CNT_LO:   bus_rdata = cnt[DATA_W-1:0];
            A_CNT_HI:   bus_rdata = cnt[CNT_W-1:DATA_W];
            A_CMP_LO:   bus_rdata = cmp[DATA_W-1:0];
            A_CMP_HI:   bus_rdata = cmp[CNT_W-1:DATA_W];
            A_INCR:     bus_rdata = incr;
            A_CTRL:     bus_rdata[2:0] = ctrl_q;
            A_IRQ_EN:   bus_rdata[0] = ien_q;
            A_IRQ_STAT: bus_rdata[0] = pending;
            A_WSTAT: begin
                bus_rdata[2:0] = gflags[2:0];
                bus_rdata[CTRL_WS_BIT] = gflags[3];
            end
            A_CNT_WST:  bus_rdata[1:0] = cflags;
            default:    bus_rdata = '0;
        endcase
    end

    // R8: the state machine is active only while the enable bit is held
    p_state_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cstate != CMP_OFF) |-> ctrl_q[EN_BIT]);
endmodule

// File: tb/gct_timer_test.sv
module gct_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    gct_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        int hit, t;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 10; a++) begin
            rd(a[3:0], v);
            chk("R1 reg read", {32'd0, v}, 64'd0);
        end
        chk("R1 irq", {63'd0, irq}, 64'd0);

        // R3 preload, R9 count flags, R10 clear
        wr(4'd0, 32'hFFFF_FFFD);
        wr(4'd1, 32'd5);
        rd(4'd0, v);  chk("R3 count low", {32'd0, v}, 64'hFFFF_FFFD);
        rd(4'd1, v);  chk("R3 count high", {32'd0, v}, 64'd5);
        rd(4'd9, v);  chk("R9 count flags low only", {32'd0, v}, 64'd1);
        tick(1);
        rd(4'd9, v);  chk("R9 count flags both", {32'd0, v}, 64'd3);
        wr(4'd9, 32'd3);
        rd(4'd9, v);  chk("R10 count flags cleared", {32'd0, v}, 64'd0);

        // R2 run with carry, R11 live read
        wr(4'd5, 32'd1);
        tick(5);
        rd(4'd0, v);  rd(4'd1, v2);
        chk("R2 carry count", {v2, v}, 64'h6_0000_0002);
        tick(1);
        rd(4'd0, v);  chk("R11 live read", {32'd0, v}, 64'd3);
        wr(4'd5, 32'd0);
        rd(4'd0, v);
        tick(4);
        rd(4'd0, v2); chk("R2 hold when stopped", {32'd0, v2}, {32'd0, v});

        // R9 / R10 global flags
        wr(4'd8, 32'h0001_0007);
        rd(4'd8, v);  chk("R10 flags clear all", {32'd0, v}, 64'd0);
        wr(4'd2, 32'd77);
        rd(4'd8, v);  chk("R9 flag not yet", {32'd0, v}, 64'd0);
        tick(1);
        rd(4'd8, v);  chk("R9 cmp low flag", {32'd0, v}, 64'd1);
        wr(4'd3, 32'd0);  tick(1);
        rd(4'd8, v);  chk("R9 cmp high flag", {32'd0, v}, 64'd3);
        wr(4'd4, 32'd9);  tick(1);
        rd(4'd8, v);  chk("R9 incr flag", {32'd0, v}, 64'd7);
        wr(4'd5, 32'd0);  tick(1);
        rd(4'd8, v);  chk("R9 ctrl flag bit16", {32'd0, v}, 64'h1_0007);
        wr(4'd8, 32'd2);
        rd(4'd8, v);  chk("R10 clear one flag", {32'd0, v}, 64'h1_0005);
        wr(4'd8, 32'd0);
        rd(4'd8, v);  chk("R10 write 0 keeps", {32'd0, v}, 64'h1_0005);
        wr(4'd8, 32'h0001_0005);
        wr(4'd2, 32'd0);
        wr(4'd8, 32'd1);
        rd(4'd8, v);  chk("R10 set beats clear", {32'd0, v}, 64'd1);
        wr(4'd8, 32'd1);
        rd(4'd8, v);  chk("R10 later clear", {32'd0, v}, 64'd0);

        // R4 one-shot distance sweep
        wr(4'd6, 32'd1);
        for (int k = 0; k <= 5; k++) begin
            wr(4'd5, 32'd0);
            wr(4'd7, 32'd1);
            wr(4'd0, 32'd100);
            wr(4'd1, 32'd0);
            wr(4'd2, 32'd100 + k);
            wr(4'd3, 32'd0);
            wr(4'd5, 32'd3);
            hit = 0;
            for (int i = 1; i <= 20; i++) begin
                tick(1);
                if (irq && hit == 0) hit = i;
            end
            chk("R4 one-shot match edge", hit, k + 1);
        end

        // R12 spent comparator stays quiet until rewritten
        wr(4'd7, 32'd1);
        wr(4'd5, 32'd2);
        wr(4'd0, 32'd100);
        wr(4'd5, 32'd3);
        tick(20);
        chk("R12 no re-fire while spent", {63'd0, irq}, 64'd0);
        wr(4'd5, 32'd2);
        wr(4'd0, 32'd100);
        wr(4'd2, 32'd105);
        wr(4'd5, 32'd3);
        hit = 0;
        for (int i = 1; i <= 20; i++) begin
            tick(1);
            if (irq && hit == 0) hit = i;
        end
        chk("R12 rearmed by compare write", hit, 6);

        // R6 gating, R7 status clear
        wr(4'd5, 32'd0);
        wr(4'd7, 32'd1);
        wr(4'd6, 32'd0);
        wr(4'd0, 32'd0);
        wr(4'd2, 32'd3);
        wr(4'd5, 32'd3);
        tick(10);
        chk("R6 irq masked", {63'd0, irq}, 64'd0);
        rd(4'd7, v);  chk("R6 status set while masked", {32'd0, v}, 64'd1);
        wr(4'd6, 32'd1);
        chk("R6 irq unmasked", {63'd0, irq}, 64'd1);
        wr(4'd7, 32'd0);
        chk("R7 write 0 no clear", {63'd0, irq}, 64'd1);
        wr(4'd7, 32'd1);
        rd(4'd7, v);  chk("R7 write 1 clears", {32'd0, v}, 64'd0);

        // R8 disable keeps pending, stops matches
        wr(4'd5, 32'd0);
        wr(4'd0, 32'd0);
        wr(4'd2, 32'd4);
        wr(4'd5, 32'd3);
        tick(8);
        chk("R8 match before disable", {63'd0, irq}, 64'd1);
        wr(4'd5, 32'd1);
        chk("R8 pending kept", {63'd0, irq}, 64'd1);
        wr(4'd7, 32'd1);
        wr(4'd2, 32'd40);
        tick(40);
        chk("R8 no match while disabled", {63'd0, irq}, 64'd0);

        // R5 auto-increment period sweep
        for (int inc = 3; inc <= 6; inc++) begin
            wr(4'd5, 32'd0);
            wr(4'd7, 32'd1);
            wr(4'd0, 32'd0);
            wr(4'd1, 32'd0);
            wr(4'd2, 32'd5);
            wr(4'd3, 32'd0);
            wr(4'd4, inc);
            wr(4'd5, 32'd7);
            t = 0;
            for (int n = 0; n < 3; n++) begin
                hit = 0;
                for (int g = 0; g < 40 && hit == 0; g++) begin
                    tick(1);
                    t++;
                    if (irq) hit = 1;
                end
                chk("R5 periodic match edge", t, 6 + n * inc);
                if (n < 2) begin
                    wr(4'd7, 32'd1);
                    t++;
                end
            end
            rd(4'd2, v);
            chk("R5 reloaded compare", {32'd0, v}, 5 + 3 * inc);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule